// File: doc/BRIEF.md
# Boot-Block Lock and Protection Unit

This block decides, for every program or erase request aimed at a word address of a flash array, whether the modification may go ahead. It turns the address into a block index on an asymmetric layout. The layout has one boot block, two small parameter blocks, one mid-size block and a run of large main blocks. The boot block sits at either the bottom or the top of the address space, chosen by a parameter. The unit keeps one lock bit per block and combines that bit with the level of the write-protect input and with the two reset conditions: deep power-down and the high-voltage unlock level.

The unit also runs the lock-related command sequences that arrive as byte writes: entering lock-status read, setting the lock bit of one block, and erasing every block that is unlocked. The storage array itself is out of scope. The unit reports the result of each request as a one-cycle grant or error pulse, and reports a bulk erase as a one-cycle strobe with a vector of the blocks to be wiped. The lock bits are volatile in this model and come out of reset unlocked.

Top module: `lockguard`

## Requirements
- R1: With BOOT_TOP=0, the block index is 0 for words 00000h-01FFFh (boot) and 1 for 02000h-02FFFh. It is 2 for 03000h-03FFFh and 3 for 04000h-07FFFh. Each 32K region from 08000h upward takes index 3 + address[18:15], so the region at 78000h takes 18.
- R2: With BOOT_TOP=1, the map is mirrored. Index 0 is 7E000h-7FFFFh, 1 is 7D000h-7DFFFh, 2 is 7C000h-7CFFFh and 3 is 78000h-7BFFFh. The 32K regions below take indices 4 upward as the address falls, ending with 18 at 00000h.
- R3: After reset, every lock bit is 1 (unlocked) and lock-status read is off. The grant, error and erase strobe outputs are 0, and ers_vec is 0.
- R4: With pwr_down=0, prot_pin=0 and hv_unlock=0, allow is 1 for a block whose lock bit is 1 and 0 for a block whose lock bit is 0.
- R5: With pwr_down=0 and either prot_pin=1 or hv_unlock=1, allow is 1 for every block, locked or not.
- R6: With pwr_down=1, allow is 0 for every block and every request is refused. Command bytes are ignored, and the sequencer and lock-status read are cleared on the next clock.
- R7: Command byte 71h turns lock-status read on: lock_rd_act=1, and lock_stat gives the lock bit of the addressed block (1 unlocked, 0 locked). Any other byte accepted outside a two-byte sequence turns it off; FFh, 70h and 90h are examples.
- R8: Byte 77h followed by D0h clears the lock bit of the block addressed by the D0h write, and only that block. If 77h is followed by any other byte, the sequence is abandoned with no change.
- R9: Byte A7h followed by D0h raises ers_stb for exactly one cycle on the next clock. Alongside it, ers_vec shows the lock bits, or all ones when prot_pin or hv_unlock is 1. In that override case all lock bits become 1.
- R10: A request raised for one cycle is answered on the next clock. When allow was 1, grant pulses. When allow was 0, pgm_err pulses for a program (req_erase=0) or ers_err for an erase (req_erase=1). At most one of the three is high.
- R11: A granted erase request returns the lock bit of its block to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| waddr | input | 19 | Word address for decode, requests and commands |
| cmd_we | input | 1 | One-cycle command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| prot_pin | input | 1 | Write-protect input level (1 = protection off) |
| pwr_down | input | 1 | Reset input held low: deep power-down |
| hv_unlock | input | 1 | Reset input at high voltage: all blocks unlocked |
| req_valid | input | 1 | One-cycle program/erase request |
| req_erase | input | 1 | Request kind: 1 erase, 0 program |
| blk_idx | output | 5 | Block index of waddr |
| allow | output | 1 | Modification of the addressed block is permitted |
| lock_rd_act | output | 1 | Lock-status read mode is on |
| lock_stat | output | 1 | Lock bit of addressed block while lock read is on |
| grant | output | 1 | Request accepted (one cycle) |
| pgm_err | output | 1 | Program request refused (one cycle) |
| ers_err | output | 1 | Erase request refused (one cycle) |
| ers_stb | output | 1 | Bulk erase of unlocked blocks (one cycle) |
| ers_vec | output | 19 | Blocks wiped by the bulk erase |

## Verification
The properties assume that a command write and a request never fall in the same cycle, so a lock-bit set and an erase grant never target the bank on one edge. They also assume that strobes last one cycle. The bench drives each command or request in its own task, with the strobe raised at a falling edge and dropped at the next one, so the stimulus never overlaps. Protect and reset-level inputs change only between operations, never while a strobe is high.

// File: rtl/lockguard_pkg.sv
// Shared command codes and sequencer state type for the lock/protection unit.
// Assumes byte-wide command codes.
package lockguard_pkg;
    localparam logic [7:0] OP_LOCKRD   = 8'h71;
    localparam logic [7:0] OP_LOCKSET  = 8'h77;
    localparam logic [7:0] OP_WIPEALL  = 8'hA7;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LSET  = 2'd1,
        SQ_WIPE  = 2'd2
    } seq_t;
endpackage

// File: rtl/lockguard_decode.sv
// Address-to-block decoder for an asymmetric boot layout.
// Assumes block sizes of 2^BOOT_AW (boot), two of 2^(BOOT_AW-1), one of
// 2^(BOOT_AW+1), then 2^(BOOT_AW+2) main blocks filling the address space.
// BOOT_TOP mirrors the map by decoding the inverted address.
module lockguard_decode #(
    parameter int AW       = 19,
    parameter int BOOT_AW  = 13,
    parameter bit BOOT_TOP = 1'b0,
    parameter int IW       = 5
) (
    input  logic [AW-1:0] waddr,
    output logic [IW-1:0] idx
);
    localparam int PARM_BIT = BOOT_AW - 1;
    localparam int MID_BIT  = BOOT_AW + 1;
    localparam int MAIN_LSB = BOOT_AW + 2;
    localparam int HIW      = AW - MAIN_LSB;

    logic [AW-1:0]  a;
    logic [HIW-1:0] hi;
    logic           unused_low;

    // Pick the address orientation at elaboration time.
    generate
        if (BOOT_TOP) begin : g_top
            assign a = ~waddr;
        end else begin : g_bot
            assign a = waddr;
        end
    endgenerate

    assign hi         = a[AW-1:MAIN_LSB];
    assign unused_low = ^a[PARM_BIT-1:0];

    // Priority decode from the large blocks down to the boot block.
    always_comb begin
        if (hi != '0)
            idx = IW'(hi) + IW'(3);
        else if (a[MID_BIT])
            idx = IW'(3);
        else if (a[BOOT_AW])
            idx = a[PARM_BIT] ? IW'(2) : IW'(1);
        else
            idx = '0;
    end
endmodule

// File: rtl/lockguard_seq.sv
// Command byte sequencer for lock operations.
// Assumes cmd_we is a one-cycle strobe; all bytes are ignored in power-down,
// which also returns the sequencer to idle and leaves lock-status read.
module lockguard_seq
    import lockguard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    output logic       lock_set_p,
    output logic       wipe_p,
    output logic       lockrd
);
    seq_t state_q, state_d;
    logic lockrd_d;
    logic take;

    assign take = cmd_we && !pwr_down;

    // Confirm pulses fire on the D0h write that completes a sequence.
    assign lock_set_p = take && (state_q == SQ_LSET) && (cmd_byte == OP_CONFIRM);
    assign wipe_p     = take && (state_q == SQ_WIPE) && (cmd_byte == OP_CONFIRM);

    // Next-state and lock-read mode selection.
    always_comb begin
        state_d  = state_q;
        lockrd_d = lockrd;
        if (pwr_down) begin
            state_d  = SQ_IDLE;
            lockrd_d = 1'b0;
        end else if (take) begin
            if (state_q == SQ_IDLE) begin
                lockrd_d = (cmd_byte == OP_LOCKRD);
                if (cmd_byte == OP_LOCKSET)
                    state_d = SQ_LSET;
                else if (cmd_byte == OP_WIPEALL)
                    state_d = SQ_WIPE;
            end else begin
                state_d = SQ_IDLE;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            lockrd  <= 1'b0;
        end else begin
            state_q <= state_d;
            lockrd  <= lockrd_d;
        end
    end
endmodule

// File: rtl/lockguard_bank.sv
// Per-block lock bits (1 = unlocked). Volatile model: reset sets all to 1.
// Assumes set and erase events for one block never share a cycle.
module lockguard_bank #(
    parameter int NBLK = 19,
    parameter int IW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   idx,
    input  logic            lock_one,
    input  logic            unlock_one,
    input  logic            unlock_all,
    output logic [NBLK-1:0] unl
);
    genvar i;
    generate
        for (i = 0; i < NBLK; i++) begin : g_bit
            // One lock bit: lock wins only when this block is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    unl[i] <= 1'b1;
                else if (unlock_all || (unlock_one && idx == IW'(i)))
                    unl[i] <= 1'b1;
                else if (lock_one && idx == IW'(i))
                    unl[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/lockguard.sv
// Boot-block lock and protection unit: decodes the block, applies the
// lock/protect/reset-level rules, answers requests one cycle later, and
// runs lock-set, lock-read and bulk-erase sequences.
// Assumes command writes and requests do not occur in the same cycle.
module lockguard #(
    parameter int AW       = 19,
    parameter int BOOT_AW  = 13,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [18:0]   waddr,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_byte,
    input  logic          prot_pin,
    input  logic          pwr_down,
    input  logic          hv_unlock,
    input  logic          req_valid,
    input  logic          req_erase,
    output logic [4:0]    blk_idx,
    output logic          allow,
    output logic          lock_rd_act,
    output logic          lock_stat,
    output logic          grant,
    output logic          pgm_err,
    output logic          ers_err,
    output logic          ers_stb,
    output logic [18:0]   ers_vec
);
    localparam int NBLK = 4 + (1 << (AW - BOOT_AW - 2)) - 1;
    localparam int IW   = $clog2(NBLK);

    logic [NBLK-1:0] unl;
    logic            lock_set_p;
    logic            wipe_p;
    logic            override;
    logic            erase_ok;

    lockguard_decode #(
        .AW(AW), .BOOT_AW(BOOT_AW), .BOOT_TOP(BOOT_TOP), .IW(IW)
    ) u_dec (
        .waddr (waddr),
        .idx   (blk_idx)
    );

    lockguard_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .cmd_we     (cmd_we),
        .cmd_byte   (cmd_byte),
        .lock_set_p (lock_set_p),
        .wipe_p     (wipe_p),
        .lockrd     (lock_rd_act)
    );

    lockguard_bank #(.NBLK(NBLK), .IW(IW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (blk_idx),
        .lock_one   (lock_set_p),
        .unlock_one (erase_ok),
        .unlock_all (wipe_p && override),
        .unl        (unl)
    );

    // Protection rule: power-down denies; pin or high voltage overrides lock.
    assign override  = prot_pin || hv_unlock;
    assign allow     = !pwr_down && (override || unl[blk_idx]);
    assign lock_stat = lock_rd_act && unl[blk_idx];
    assign erase_ok  = req_valid && allow && req_erase;

    // Request outcome registers, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant   <= 1'b0;
            pgm_err <= 1'b0;
            ers_err <= 1'b0;
        end else begin
            grant   <= req_valid && allow;
            pgm_err <= req_valid && !allow && !req_erase;
            ers_err <= req_valid && !allow && req_erase;
        end
    end

    // Bulk-erase strobe and the set of blocks it wipes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ers_stb <= 1'b0;
            ers_vec <= '0;
        end else begin
            ers_stb <= wipe_p;
            if (wipe_p)
                ers_vec <= override ? '1 : unl;
        end
    end
endmodule

// File: rtl/lockguard_chk.sv
// Property checker for lockguard, attached with bind.
// Assumes requests and command writes never share a cycle.
module lockguard_chk #(
    parameter int NBLK = 19,
    parameter int IW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_erase,
    input logic            allow,
    input logic            pwr_down,
    input logic            grant,
    input logic            pgm_err,
    input logic            ers_err,
    input logic            ers_stb,
    input logic            lock_rd_act,
    input logic            lock_set_p,
    input logic [NBLK-1:0] unl,
    input logic [IW-1:0]   blk_idx
);
    a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, pgm_err, ers_err}));

    a_r10_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && !$past(allow) |-> !grant && (pgm_err || ers_err));

    a_r6_pd_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(pwr_down) |-> !grant);

    a_r6_pd_leaves_lockrd: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !lock_rd_act);

    a_r8_set_locks_block: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set_p |=> !unl[$past(blk_idx)]);

    a_r11_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && grant && $past(req_erase) |-> unl[$past(blk_idx)]);

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        ers_stb |=> !ers_stb);
endmodule

bind lockguard lockguard_chk #(.NBLK(NBLK), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_erase   (req_erase),
    .allow       (allow),
    .pwr_down    (pwr_down),
    .grant       (grant),
    .pgm_err     (pgm_err),
    .ers_err     (ers_err),
    .ers_stb     (ers_stb),
    .lock_rd_act (lock_rd_act),
    .lock_set_p  (lock_set_p),
    .unl         (unl),
    .blk_idx     (blk_idx)
);

// File: tb/sim_lockguard.sv
module sim_lockguard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] waddr = '0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        prot_pin = 1'b0;
    logic        pwr_down = 1'b0;
    logic        hv_unlock = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;

    logic [4:0]  idx0, idx1;
    logic        allow0, allow1, lra0, lra1, lst0, lst1;
    logic        gr0, gr1, pe0, pe1, ee0, ee1, stb0, stb1;
    logic [18:0] vec0, vec1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lockguard #(.BOOT_TOP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .waddr(waddr), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .prot_pin(prot_pin), .pwr_down(pwr_down), .hv_unlock(hv_unlock),
        .req_valid(req_valid), .req_erase(req_erase), .blk_idx(idx0), .allow(allow0),
        .lock_rd_act(lra0), .lock_stat(lst0), .grant(gr0), .pgm_err(pe0), .ers_err(ee0),
        .ers_stb(stb0), .ers_vec(vec0));

    lockguard #(.BOOT_TOP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .waddr(waddr), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .prot_pin(prot_pin), .pwr_down(pwr_down), .hv_unlock(hv_unlock),
        .req_valid(req_valid), .req_erase(req_erase), .blk_idx(idx1), .allow(allow1),
        .lock_rd_act(lra1), .lock_stat(lst1), .grant(gr1), .pgm_err(pe1), .ers_err(ee1),
        .ers_stb(stb1), .ers_vec(vec1));

    // Decode vectors: address, bottom-boot index, top-boot index.
    localparam logic [28:0] DEC_TAB [16] = '{
        {19'h00000, 5'd0,  5'd18}, {19'h01FFF, 5'd0,  5'd18},
        {19'h02000, 5'd1,  5'd18}, {19'h03000, 5'd2,  5'd18},
        {19'h04000, 5'd3,  5'd18}, {19'h07FFF, 5'd3,  5'd18},
        {19'h08000, 5'd4,  5'd17}, {19'h10000, 5'd5,  5'd16},
        {19'h3A123, 5'd10, 5'd11}, {19'h7C000, 5'd18, 5'd2},
        {19'h7D000, 5'd18, 5'd1},  {19'h7E000, 5'd18, 5'd0},
        {19'h7BFFF, 5'd18, 5'd3},  {19'h78000, 5'd18, 5'd3},
        {19'h7FFFF, 5'd18, 5'd0},  {19'h6FFFF, 5'd16, 5'd5}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_cmd(input logic [7:0] b, input logic [18:0] a);
        @(negedge clk);
        waddr = a; cmd_byte = b; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic put_req(input logic ers, input logic [18:0] a);
        @(negedge clk);
        waddr = a; req_erase = ers; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic at_addr(input logic [18:0] a);
        waddr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        at_addr(19'h02000);
        check("R3 allow after reset", allow0, 1);
        check("R3 lock read off", lra0, 0);
        check("R3 grant idle", gr0, 0);
        check("R3 strobe idle", stb0, 0);
        check("R3 vec clear", vec0, 0);

        // R1/R2: table walk over both layouts
        for (int k = 0; k < 16; k++) begin
            at_addr(DEC_TAB[k][28:10]);
            check("R1 bottom decode", idx0, DEC_TAB[k][9:5]);
            check("R2 top decode", idx1, DEC_TAB[k][4:0]);
        end

        // R7: lock-status read on, block unlocked
        put_cmd(8'h71, 19'h0);
        at_addr(19'h02000);
        check("R7 lock read on", lra0, 1);
        check("R7 unlocked reads 1", lst0, 1);

        // R8: lock block 1 only
        put_cmd(8'h77, 19'h02000);
        check("R7 other byte leaves lock read", lra0, 0);
        put_cmd(8'hD0, 19'h02000);
        put_cmd(8'h71, 19'h0);
        at_addr(19'h02000);
        check("R8 locked block reads 0", lst0, 0);
        check("R4 locked block denied", allow0, 0);
        at_addr(19'h03000);
        check("R8 neighbour stays unlocked", lst0, 1);
        check("R4 unlocked block allowed", allow0, 1);
        put_cmd(8'hFF, 19'h0);
        check("R7 FFh leaves lock read", lra0, 0);

        // R8: abandoned sequence leaves bit alone
        put_cmd(8'h77, 19'h03000);
        put_cmd(8'h70, 19'h03000);
        at_addr(19'h03000);
        check("R8 abandoned set no change", allow0, 1);

        // R5: overrides
        prot_pin = 1'b1;
        at_addr(19'h02000);
        check("R5 protect pin high overrides", allow0, 1);
        prot_pin = 1'b0; hv_unlock = 1'b1;
        at_addr(19'h02000);
        check("R5 high voltage overrides", allow0, 1);
        hv_unlock = 1'b0;
        at_addr(19'h02000);
        check("R4 lock back in force", allow0, 0);

        // R10: request outcomes
        put_req(1'b0, 19'h02000);
        check("R10 program refused err", pe0, 1);
        check("R10 program refused no grant", gr0, 0);
        put_req(1'b1, 19'h02000);
        check("R10 erase refused err", ee0, 1);
        check("R10 erase refused pgm clear", pe0, 0);
        put_req(1'b0, 19'h03000);
        check("R10 program granted", gr0, 1);

        // R6: power-down
        put_cmd(8'h71, 19'h0);
        pwr_down = 1'b1;
        at_addr(19'h03000);
        check("R6 power-down denies", allow0, 0);
        put_req(1'b0, 19'h03000);
        check("R6 power-down request refused", pe0, 1);
        check("R6 power-down exits lock read", lra0, 0);
        put_cmd(8'h77, 19'h03000);
        put_cmd(8'hD0, 19'h03000);
        pwr_down = 1'b0;
        at_addr(19'h03000);
        check("R6 commands ignored in power-down", allow0, 1);

        // R9: bulk erase with protection active
        put_cmd(8'hA7, 19'h0);
        put_cmd(8'hD0, 19'h0);
        check("R9 strobe raised", stb0, 1);
        check("R9 vector skips locked", vec0, 32'h7FFFD);
        @(negedge clk);
        check("R9 strobe one cycle", stb0, 0);
        at_addr(19'h02000);
        check("R9 locked block still locked", allow0, 0);

        // R9: bulk erase with override unlocks everything
        prot_pin = 1'b1;
        put_cmd(8'hA7, 19'h0);
        put_cmd(8'hD0, 19'h0);
        check("R9 override vector all", vec0, 32'h7FFFF);
        prot_pin = 1'b0;
        at_addr(19'h02000);
        check("R9 lock bits returned to 1", allow0, 1);

        // R11: granted erase unlocks the block
        put_cmd(8'h77, 19'h02000);
        put_cmd(8'hD0, 19'h02000);
        at_addr(19'h02000);
        check("R11 relocked", allow0, 0);
        hv_unlock = 1'b1;
        put_req(1'b1, 19'h02000);
        check("R11 erase granted under override", gr0, 1);
        hv_unlock = 1'b0;
        at_addr(19'h02000);
        check("R11 erased block unlocked", allow0, 1);

        // R2: top-boot boot block lock
        put_cmd(8'h77, 19'h7E000);
        put_cmd(8'hD0, 19'h7E000);
        at_addr(19'h7FFFF);
        check("R2 top boot block locked", allow1, 0);
        at_addr(19'h7D000);
        check("R2 top parameter block free", allow1, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule